// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor with one accumulator. It reads 16-bit instruction words from a synchronous single-port memory, one word per address, and runs them one after another. Each instruction word has a 4-bit operation code in its upper bits and a 12-bit direct word address in its lower bits. Three operations are defined. The first copies a memory word into the accumulator. The second adds a memory word to the accumulator. The third writes the accumulator to memory.

Every instruction has two phases, a fetch phase and then an execute phase. Memory data returns one cycle after the address is driven, so each phase uses a request cycle and a capture cycle. An instruction therefore takes four cycles. After reset the program counter holds a start address that is set by a parameter, and the core begins fetching there. An undefined operation code stops the core for good, and the core then raises a halt output.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, halt_o is 0, mem_we_o is 0 and mem_addr_o equals the parameter RESET_PC (default 12'h300).
- R2: The fetch of each instruction drives mem_addr_o with the program counter. The word read there is taken as the instruction, and the program counter then steps by one. The k-th instruction after reset is fetched from RESET_PC+k in cycle 4k, where cycle 0 is the first cycle after reset is released.
- R3: Operation code 4'h1 (bits 15:12) loads the word at the address in bits 11:0 into the accumulator and replaces its old value. The accumulator changes only in the last cycle of an execute phase.
- R4: Operation code 4'h5 adds the word at the address in bits 11:0 to the accumulator. The sum wraps modulo 2^16 and raises no flag.
- R5: Operation code 4'h2 drives mem_we_o high for exactly one cycle, cycle 4k+2 of instruction k. In that cycle mem_addr_o carries bits 11:0 of the instruction and mem_wdata_o carries the accumulator. mem_we_o is low at all other times.
- R6: Every defined instruction takes exactly four cycles: fetch request, fetch capture, execute request and execute capture, in that order.
- R7: Any operation code other than 4'h1, 4'h2 and 4'h5 raises halt_o from cycle 4k+3 of instruction k. After that halt_o stays high until reset, no memory write occurs, and mem_addr_o holds RESET_PC+k+1.
- R8: The accumulator resets to zero, so a store issued before any load writes 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Word address to memory |
| mem_wdata_o | output | 16 | Data to be written to memory |
| mem_we_o | output | 1 | Write enable for memory |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| halt_o | output | 1 | Sticky stop flag for an undefined operation code |

## Verification
The assertions check the phase order on every cycle. They also check that a write happens only in an execute request and lasts one cycle, that the program counter steps by exactly one after each fetch, that the accumulator changes only at the end of an execute phase, and that halt stays set with the address frozen. The values themselves can only be shown by the bench's scenarios. These are the loaded and summed data, the wrap of the sum, the zero store after reset, the fetch addresses, and the exact cycles of the write and the halt. The bench runs all sixteen operation codes, a grid of add operands around the wrap point, and add chains of several lengths.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'h5;

  typedef enum logic [2:0] {
    PH_FETCH_REQ,
    PH_FETCH_CAP,
    PH_EXEC_REQ,
    PH_EXEC_CAP,
    PH_HALT
  } phase_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_ADD,
    ACT_STORE
  } act_e;
endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output act_e            act_o,
  output logic            illegal_o
);
  always_comb begin
    act_o     = ACT_NONE;
    illegal_o = 1'b0;
    unique case (opcode_i)
      OPC_LOAD:  act_o = ACT_LOAD;
      OPC_ADD:   act_o = ACT_ADD;
      OPC_STORE: act_o = ACT_STORE;
      default:   illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  act_e act_i,
  input  logic illegal_i,
  output logic fetch_cap_o,
  output logic exec_req_o,
  output logic exec_cap_o,
  output logic mem_we_o,
  output logic halt_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_FETCH_REQ: state_d = PH_FETCH_CAP;
      PH_FETCH_CAP: state_d = PH_EXEC_REQ;
      PH_EXEC_REQ:  state_d = illegal_i ? PH_HALT : PH_EXEC_CAP;
      PH_EXEC_CAP:  state_d = PH_FETCH_REQ;
      PH_HALT:      state_d = PH_HALT;
      default:      state_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_FETCH_REQ;
    else         state_q <= state_d;
  end

  assign fetch_cap_o = (state_q == PH_FETCH_CAP);
  assign exec_req_o  = (state_q == PH_EXEC_REQ);
  assign exec_cap_o  = (state_q == PH_EXEC_CAP);
  assign halt_o      = (state_q == PH_HALT);
  // write only for a decoded store, never on the halting cycle
  assign mem_we_o    = exec_req_o && !illegal_i && (act_i == ACT_STORE);
endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
  import acc_core_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_cap_i,
  input  logic              exec_req_i,
  input  logic              exec_cap_i,
  input  act_e              act_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] operand_addr;

  assign operand_addr = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
    end else if (fetch_cap_i) begin
      ir_q <= mem_rdata_i;
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (exec_cap_i) begin
      unique case (act_i)
        ACT_LOAD: acc_q <= mem_rdata_i;
        ACT_ADD:  acc_q <= acc_q + mem_rdata_i;
        default:  acc_q <= acc_q;
      endcase
    end
  end

  assign mem_addr_o  = exec_req_i ? operand_addr : pc_q;
  assign mem_wdata_o = acc_q;
  assign opcode_o    = ir_q[DATA_W-1 -: OP_W];
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = DATA_W - OP_W,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halt_o
);
  act_e              act;
  logic              illegal;
  logic              fetch_cap;
  logic              exec_req;
  logic              exec_cap;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q;

  acc_core_decode u_decode (
    .opcode_i  (opcode),
    .act_o     (act),
    .illegal_o (illegal)
  );

  acc_core_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .illegal_i   (illegal),
    .fetch_cap_o (fetch_cap),
    .exec_req_o  (exec_req),
    .exec_cap_o  (exec_cap),
    .mem_we_o    (mem_we_o),
    .halt_o      (halt_o)
  );

  acc_core_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_cap_i (fetch_cap),
    .exec_req_i  (exec_req),
    .exec_cap_i  (exec_cap),
    .act_i       (act),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .opcode_o    (opcode),
    .pc_o        (pc_q),
    .acc_o       (acc_q)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              fetch_cap_i,
  input logic              exec_req_i,
  input logic              exec_cap_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] acc_i
);
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_cap_i, exec_req_i, exec_cap_i, halt_i})); // R6
  AST_FETCH_TO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_cap_i |=> exec_req_i); // R6
  AST_EXEC_REQ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_req_i |=> (exec_cap_i || halt_i)); // R6
  AST_EXEC_CAP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_cap_i |=> !(fetch_cap_i || exec_req_i || exec_cap_i || halt_i)); // R6
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_cap_i |=> (pc_i == $past(pc_i) + 1'b1)); // R2
  AST_ACC_AT_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_i) |-> $past(exec_cap_i)); // R3
  AST_WE_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> exec_req_i); // R5
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i); // R5
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> halt_i); // R7
  AST_HALT_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !mem_we_i); // R7
  AST_HALT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(mem_addr_i)); // R7
endmodule

bind acc_core acc_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_o),
  .mem_we_i    (mem_we_o),
  .mem_addr_i  (mem_addr_o),
  .fetch_cap_i (fetch_cap),
  .exec_req_i  (exec_req),
  .exec_cap_i  (exec_cap),
  .pc_i        (pc_q),
  .acc_i       (acc_q)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 12;
  localparam int unsigned WORDS = 1 << AW;
  localparam logic [AW-1:0] START = 12'h300;
  localparam int MAXC = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halt;

  logic [DW-1:0] mem [WORDS];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int wr_cnt, wr_cyc, halt_cyc;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] fetch_addr [8];
  logic [AW-1:0] addr_at_end;
  bit halt_dropped;

  always #5 clk = ~clk;

  acc_core u_acc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  endtask

  // runs from reset for ncyc cycles and records what appears on the ports
  task automatic run(input int ncyc);
    rst_ni = 1'b0;
    wr_cnt = 0; wr_cyc = -1; halt_cyc = -1;
    wr_addr = '0; wr_data = '0; halt_dropped = 1'b0;
    for (int i = 0; i < 8; i++) fetch_addr[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!halt && !mem_we && mem_addr == START, "R1 reset outputs",
        {halt, mem_we, 2'b0, mem_addr}, {4'b0, START});
    rst_ni = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) @(negedge clk);
      if (c % 4 == 0 && c / 4 < 8) fetch_addr[c / 4] = mem_addr;
      if (mem_we) begin
        wr_cnt++;
        if (wr_cyc < 0) begin
          wr_cyc = c; wr_addr = mem_addr; wr_data = mem_wdata;
        end
      end
      if (halt && halt_cyc < 0) halt_cyc = c;
      if (!halt && halt_cyc >= 0) halt_dropped = 1'b1;
    end
    addr_at_end = mem_addr;
    @(posedge clk);
  endtask

  logic [DW-1:0] vals [5] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff};

  initial begin
    // load/add/store program, operand grid around the wrap point (R2 R4 R5 R6 R7)
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        logic [DW-1:0] a, b, s;
        a = vals[i] ^ 16'(j * 16'h0101);
        b = vals[j];
        s = a + b;
        clear_mem();
        mem[12'h300] = ins(4'h1, 12'h940);
        mem[12'h301] = ins(4'h5, 12'h941);
        mem[12'h302] = ins(4'h2, 12'h941);
        mem[12'h303] = 16'h0000;
        mem[12'h940] = a;
        mem[12'h941] = b;
        run(40);
        chk(mem[12'h941] == s, "R4 wrapped sum", mem[12'h941], s);
        if (i == 0 && j == 0) begin
          for (int k = 0; k < 4; k++)
            chk(fetch_addr[k] == START + AW'(k), "R2 fetch address", fetch_addr[k], START + AW'(k));
          chk(wr_cnt == 1 && wr_cyc == 10, "R5 write cycle", wr_cyc, 10);
          chk(wr_addr == 12'h941, "R5 write address", wr_addr, 12'h941);
          chk(halt_cyc == 15, "R7 halt cycle", halt_cyc, 15);
          chk(addr_at_end == 12'h304, "R7 frozen address", addr_at_end, 12'h304);
          chk(!halt_dropped, "R7 halt sticky", halt_dropped, 0);
        end
      end
    end

    // every opcode in the first slot, followed by a store and a halt (R3 R4 R5 R7 R8)
    for (int op = 0; op < 16; op++) begin
      logic [DW-1:0] exp20, exp30;
      int exp_halt, exp_wr;
      clear_mem();
      mem[12'h300] = ins(4'(op), 12'h020);
      mem[12'h301] = ins(4'h2, 12'h030);
      mem[12'h302] = 16'h0000;
      mem[12'h020] = 16'hbeef;
      mem[12'h030] = 16'h1234;
      run(30);
      case (op)
        1, 5: begin exp20 = 16'hbeef; exp30 = 16'hbeef; exp_halt = 11; exp_wr = 1; end
        2:    begin exp20 = 16'h0000; exp30 = 16'h0000; exp_halt = 11; exp_wr = 2; end
        default: begin exp20 = 16'hbeef; exp30 = 16'h1234; exp_halt = 3; exp_wr = 0; end
      endcase
      chk(mem[12'h020] == exp20, "R3 R8 opcode sweep word 020", mem[12'h020], exp20);
      chk(mem[12'h030] == exp30, "R3 R4 opcode sweep word 030", mem[12'h030], exp30);
      chk(halt_cyc == exp_halt, "R7 opcode sweep halt cycle", halt_cyc, exp_halt);
      chk(wr_cnt == exp_wr, "R5 R7 opcode sweep write count", wr_cnt, exp_wr);
      if (exp_halt == 3)
        chk(addr_at_end == 12'h301, "R7 halted address", addr_at_end, 12'h301);
    end

    // accumulating chains of different lengths (R4 R6)
    for (int n = 1; n <= 8; n++) begin
      logic [DW-1:0] sum;
      clear_mem();
      sum = '0;
      for (int k = 0; k < n; k++) begin
        mem[12'h100 + k] = 16'(k * 16'h2345 + 16'hf00d);
        sum = sum + mem[12'h100 + k];
        mem[START + AW'(k)] = ins(k == 0 ? 4'h1 : 4'h5, 12'h100 + AW'(k));
      end
      mem[START + AW'(n)] = ins(4'h2, 12'h200);
      mem[START + AW'(n + 1)] = 16'hf000;
      run(4 * n + 12);
      chk(mem[12'h200] == sum, "R4 chain sum", mem[12'h200], sum);
      chk(wr_cyc == 4 * n + 2, "R6 chain write cycle", wr_cyc, 4 * n + 2);
      chk(halt_cyc == 4 * n + 7, "R6 chain halt cycle", halt_cyc, 4 * n + 7);
    end

    // a second load replaces the first (R3)
    clear_mem();
    mem[12'h300] = ins(4'h1, 12'h040);
    mem[12'h301] = ins(4'h1, 12'h041);
    mem[12'h302] = ins(4'h2, 12'h042);
    mem[12'h303] = 16'h3000;
    mem[12'h040] = 16'haaaa;
    mem[12'h041] = 16'h5555;
    run(20);
    chk(mem[12'h042] == 16'h5555, "R3 load replaces", mem[12'h042], 16'h5555);
    chk(wr_data == 16'h5555, "R5 write data", wr_data, 16'h5555);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule